// File: doc/BRIEF.md
# Single-Precision Float Compare and Min/Max Unit

This unit takes two 32-bit IEEE-754 single-precision operands and a three-bit operation code. It performs one of five functions: equality test, less-than test, less-or-equal test, minimum or maximum. The three tests return 0 or 1 in a 32-bit result. Minimum and maximum return a 32-bit float. An invalid-operation flag comes out with every result.

An operation is accepted when `inStrobe` is high. The result and the flag are registered, and they appear one cycle later with `outStrobe` high. The unit sorts each operand into one of several classes: zero, infinity, quiet NaN, signaling NaN, or a finite nonzero value. These classes decide the NaN and signed-zero behaviour the requirements list.

Top module: `fcmp_minmax`

## Requirements
- R1: `outStrobe` is high in exactly the cycle after a cycle where `inStrobe` is high, and is low after reset.
- R2: Operation code 0 (equality) gives 1 when the operands are numerically equal, with +0 equal to -0, and gives 0 otherwise. The flag is raised only when an operand is a signaling NaN (exponent 0xFF, mantissa nonzero, mantissa bit 22 clear).
- R3: Operation code 1 (less-than) and code 2 (less-or-equal) order non-NaN values numerically, with +0 and -0 equal. If either operand is any NaN, the result is 0 and the flag is raised.
- R4: For operation codes 3 (minimum) and 4 (maximum), the flag is raised only when an operand is a signaling NaN.
- R5: For minimum and maximum, when exactly one operand is a NaN, the other operand is returned bit-for-bit.
- R6: For minimum and maximum, when both operands are NaN, the result is the canonical NaN 0x7FC00000.
- R7: For zeros of opposite sign, minimum returns 0x80000000 and maximum returns 0x00000000.
- R8: In all other cases, minimum returns the numerically smaller operand and maximum the larger.
- R9: Operation codes 5 to 7 give result 0 and no flag.
- R10: Result and flag hold their values in cycles without `inStrobe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rstN | input | 1 | active-low synchronous reset |
| inStrobe | input | 1 | operands and code are valid this cycle |
| opCode | input | 3 | operation select |
| srcA | input | 32 | first operand |
| srcB | input | 32 | second operand |
| outStrobe | output | 1 | result and flag valid |
| result | output | 32 | registered result |
| invalidFlag | output | 1 | registered invalid-operation flag |

## Verification
The class decode and the sign-magnitude ordering could be wrong inside. Every such fault would show up in the first registered result for an affected operand pair, one cycle after the strobe. The sweep crosses a set of operands covering every class with every operation code. A wrong class, such as a quiet NaN decoded as signaling, would therefore show as a wrong flag or a wrong selected operand within one cycle. A stuck strobe register would show as `outStrobe` misaligned with `inStrobe`.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  localparam int unsigned WIDTH = 32;
  localparam int unsigned EXP_W = 8;
  localparam int unsigned MAN_W = 23;
  localparam int unsigned OP_W = 3;
  localparam logic [WIDTH-1:0] CANON_NAN = 32'h7FC0_0000;

  typedef enum logic [OP_W-1:0] {
    OP_EQ  = 3'd0,
    OP_LT  = 3'd1,
    OP_LE  = 3'd2,
    OP_MIN = 3'd3,
    OP_MAX = 3'd4
  } opSel_e;

  typedef struct packed {
    logic isZero;
    logic isInf;
    logic isQnan;
    logic isSnan;
    logic isNan;
  } fpClass_t;

  typedef struct packed {
    logic load;
    logic doEq;
    logic doLt;
    logic doLe;
    logic doMin;
    logic doMax;
  } ctrlStrobe_t;
endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
  import fcmp_pkg::*;
(
  input  logic [WIDTH-1:0] value,
  output fpClass_t         cls
);
  localparam int unsigned QBIT = MAN_W - 1;
  logic [EXP_W-1:0] expField;
  logic [MAN_W-1:0] manField;
  logic expOnes;

  always_comb begin
    expField   = value[WIDTH-2 -: EXP_W];
    manField   = value[MAN_W-1:0];
    expOnes    = &expField;
    cls.isZero = (value[WIDTH-2:0] == '0);
    cls.isInf  = expOnes && (manField == '0);
    cls.isNan  = expOnes && (manField != '0);
    cls.isQnan = cls.isNan && manField[QBIT];
    cls.isSnan = cls.isNan && !manField[QBIT];
  end
endmodule

// File: rtl/fcmp_ctrl.sv
module fcmp_ctrl
  import fcmp_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            inStrobe,
  input  logic [OP_W-1:0] opCode,
  output ctrlStrobe_t     strb,
  output logic            outStrobe
);
  always_comb begin
    strb       = '0;
    strb.load  = inStrobe;
    strb.doEq  = (opCode == OP_EQ);
    strb.doLt  = (opCode == OP_LT);
    strb.doLe  = (opCode == OP_LE);
    strb.doMin = (opCode == OP_MIN);
    strb.doMax = (opCode == OP_MAX);
  end

  always_ff @(posedge clk) begin
    if (!rstN) outStrobe <= 1'b0;
    else       outStrobe <= inStrobe;
  end
endmodule

// File: rtl/fcmp_datapath.sv
module fcmp_datapath
  import fcmp_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strb,
  input  logic [WIDTH-1:0] srcA,
  input  logic [WIDTH-1:0] srcB,
  output logic [WIDTH-1:0] result,
  output logic             invalidFlag
);
  fpClass_t clsA, clsB;
  logic [WIDTH-1:0] nextRes;
  logic nextFlag;
  logic anyNan, anySnan, bothZero, eqVal, ltVal, magLt, magEq;
  logic signA, signB;

  fcmp_classify uClsA (.value(srcA), .cls(clsA));
  fcmp_classify uClsB (.value(srcB), .cls(clsB));

  always_comb begin
    signA    = srcA[WIDTH-1];
    signB    = srcB[WIDTH-1];
    anyNan   = clsA.isNan || clsB.isNan;
    anySnan  = clsA.isSnan || clsB.isSnan;
    bothZero = clsA.isZero && clsB.isZero;
    magLt    = srcA[WIDTH-2:0] < srcB[WIDTH-2:0];
    magEq    = srcA[WIDTH-2:0] == srcB[WIDTH-2:0];
    eqVal    = !anyNan && (bothZero || (srcA == srcB));
    if (anyNan || bothZero) ltVal = 1'b0;
    else if (signA != signB) ltVal = signA;
    else if (signA) ltVal = !magLt && !magEq;
    else ltVal = magLt;
    nextRes  = '0;
    nextFlag = 1'b0;
    if (strb.doEq) begin
      nextRes[0] = eqVal;
      nextFlag   = anySnan;
    end else if (strb.doLt) begin
      nextRes[0] = ltVal;
      nextFlag   = anyNan;
    end else if (strb.doLe) begin
      nextRes[0] = ltVal || eqVal;
      nextFlag   = anyNan;
    end else if (strb.doMin || strb.doMax) begin
      nextFlag = anySnan;
      if (clsA.isNan && clsB.isNan) nextRes = CANON_NAN;
      else if (clsA.isNan) nextRes = srcB;
      else if (clsB.isNan) nextRes = srcA;
      else if (bothZero) begin
        if (strb.doMin) nextRes = (signA ? srcA : srcB);
        else            nextRes = (signA ? srcB : srcA);
      end else if (strb.doMin) nextRes = ltVal ? srcA : srcB;
      else nextRes = ltVal ? srcB : srcA;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result      <= '0;
      invalidFlag <= 1'b0;
    end else if (strb.load) begin
      result      <= nextRes;
      invalidFlag <= nextFlag;
    end
  end
endmodule

// File: rtl/fcmp_minmax.sv
module fcmp_minmax
  import fcmp_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inStrobe,
  input  logic [OP_W-1:0]  opCode,
  input  logic [WIDTH-1:0] srcA,
  input  logic [WIDTH-1:0] srcB,
  output logic             outStrobe,
  output logic [WIDTH-1:0] result,
  output logic             invalidFlag
);
  ctrlStrobe_t strb;

  fcmp_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .inStrobe(inStrobe), .opCode(opCode),
    .strb(strb), .outStrobe(outStrobe)
  );

  fcmp_datapath uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .srcA(srcA), .srcB(srcB),
    .result(result), .invalidFlag(invalidFlag)
  );
endmodule

// File: rtl/fcmp_minmax_chk.sv
module fcmp_minmax_chk
  import fcmp_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             inStrobe,
  input logic [OP_W-1:0]  opCode,
  input logic [WIDTH-1:0] srcA,
  input logic [WIDTH-1:0] srcB,
  input logic             outStrobe,
  input logic [WIDTH-1:0] result,
  input logic             invalidFlag
);
  logic aNan, bNan, aSnan, bSnan;
  assign aNan  = (&srcA[30:23]) && (srcA[22:0] != 0);
  assign bNan  = (&srcB[30:23]) && (srcB[22:0] != 0);
  assign aSnan = aNan && !srcA[22];
  assign bSnan = bNan && !srcB[22];

  AST_OUT_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    inStrobe |=> outStrobe); // R1
  AST_NO_SPURIOUS_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !inStrobe |=> !outStrobe); // R1
  AST_EQ_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (inStrobe && opCode == 3'd0) |=> (invalidFlag == $past(aSnan || bSnan))); // R2
  AST_ORD_NAN: assert property (@(posedge clk) disable iff (!rstN)
    (inStrobe && (opCode == 3'd1 || opCode == 3'd2) && (aNan || bNan))
      |=> (invalidFlag && result == 0)); // R3
  AST_MM_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (inStrobe && (opCode == 3'd3 || opCode == 3'd4)) |=> (invalidFlag == $past(aSnan || bSnan))); // R4
  AST_CANON: assert property (@(posedge clk) disable iff (!rstN)
    (inStrobe && (opCode == 3'd3 || opCode == 3'd4) && aNan && bNan) |=> (result == CANON_NAN)); // R6
  AST_UNUSED_OP: assert property (@(posedge clk) disable iff (!rstN)
    (inStrobe && opCode > 3'd4) |=> (result == 0 && !invalidFlag)); // R9
  AST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !inStrobe |=> ($stable(result) && $stable(invalidFlag))); // R10
endmodule

bind fcmp_minmax fcmp_minmax_chk uChk (
  .clk(clk), .rstN(rstN), .inStrobe(inStrobe), .opCode(opCode), .srcA(srcA),
  .srcB(srcB), .outStrobe(outStrobe), .result(result), .invalidFlag(invalidFlag)
);

// File: tb/sim_fcmp_minmax.sv
`timescale 1ns/1ps
module sim_fcmp_minmax;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inStrobe = 1'b0;
  logic [2:0] opCode = '0;
  logic [31:0] srcA = '0, srcB = '0;
  logic outStrobe;
  logic [31:0] result;
  logic invalidFlag;
  int total = 0, bad = 0;
  logic [31:0] pool [0:13];

  always #5 clk = ~clk;

  fcmp_minmax u0 (.clk(clk), .rstN(rstN), .inStrobe(inStrobe), .opCode(opCode),
    .srcA(srcA), .srcB(srcB), .outStrobe(outStrobe), .result(result),
    .invalidFlag(invalidFlag));

  function automatic bit isNan(input logic [31:0] v);
    return (v[30:23] == 8'hFF) && (v[22:0] != 0);
  endfunction
  function automatic bit isSnan(input logic [31:0] v);
    return isNan(v) && !v[22];
  endfunction
  function automatic bit isZ(input logic [31:0] v);
    return v[30:0] == 0;
  endfunction
  // signed key: monotonic mapping of non-NaN floats, zeros merged
  function automatic longint key(input logic [31:0] v);
    if (isZ(v)) return 0;
    return v[31] ? -longint'(v[30:0]) : longint'(v[30:0]);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic runOp(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] expR;
    logic expF;
    string tag;
    bit an, bn;
    an = isNan(a); bn = isNan(b);
    expR = 0; expF = 0; tag = "R9";
    case (op)
      3'd0: begin tag = "R2"; expF = isSnan(a) || isSnan(b);
        expR = (!an && !bn && key(a) == key(b)) ? 1 : 0; end
      3'd1, 3'd2: begin tag = "R3"; expF = an || bn;
        if (!an && !bn) expR = (op == 3'd1) ? (key(a) < key(b)) : (key(a) <= key(b)); end
      3'd3, 3'd4: begin
        expF = isSnan(a) || isSnan(b);
        if (an && bn) begin expR = 32'h7FC00000; tag = "R6"; end
        else if (an) begin expR = b; tag = "R5"; end
        else if (bn) begin expR = a; tag = "R5"; end
        else if (isZ(a) && isZ(b)) begin tag = "R7";
          expR = (op == 3'd3) ? ((a[31] || b[31]) ? 32'h80000000 : 32'h0)
                              : ((a[31] && b[31]) ? 32'h80000000 : 32'h0); end
        else begin tag = "R8";
          expR = (op == 3'd3) ? ((key(a) < key(b)) ? a : b)
                              : ((key(a) > key(b)) ? a : b); end
      end
      default: ;
    endcase
    @(negedge clk);
    inStrobe = 1; opCode = op; srcA = a; srcB = b;
    @(negedge clk);
    inStrobe = 0;
    check("R1", {31'b0, outStrobe}, 1);
    check(tag, result, expR);
    check((op == 3'd3 || op == 3'd4) ? "R4" : tag, {31'b0, invalidFlag}, {31'b0, expF});
    srcA = ~a; srcB = ~b; opCode = 3'd3;
    @(negedge clk);
    check("R10", result, expR);
    check("R1", {31'b0, outStrobe}, 0);
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=hang expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    pool[0] = 32'h00000000; pool[1] = 32'h80000000; pool[2] = 32'h3F800000;
    pool[3] = 32'hBF800000; pool[4] = 32'h40000000; pool[5] = 32'h7F800000;
    pool[6] = 32'hFF800000; pool[7] = 32'h7FC00000; pool[8] = 32'hFFC12345;
    pool[9] = 32'h7F800001; pool[10] = 32'hFFA00000; pool[11] = 32'h00000001;
    pool[12] = 32'h80000001; pool[13] = 32'h3F800001;
    repeat (3) @(negedge clk);
    check("R1", {31'b0, outStrobe}, 0);
    check("R10", result, 0);
    rstN = 1;
    for (int op = 0; op < 8; op++)
      for (int i = 0; i < 14; i++)
        for (int j = 0; j < 14; j++)
          runOp(op[2:0], pool[i], pool[j]);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule